// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the eight pins of a general-purpose I/O port and turns pin activity into sticky interrupt status. Each pin is configured on its own. It can sense edges or levels. In edge mode it can catch both edges or a single edge, and a polarity bit chooses which edge. In level mode the same polarity bit chooses whether high or low is the active level. Pin values come from outside the clock domain, so they pass through a multi-flop synchronizer. Edges are found by comparing the synchronized value with a registered copy of the previous sample.

Each detected event sets a bit in the raw status vector. That bit stays set until software clears it with a write-one-to-clear strobe. The surrounding register block keeps the configuration registers and drives them into the detector as plain inputs. It also reads back the raw and masked status. The single request line goes to the interrupt controller.

The asynchronous reset input is expected to be already released synchronously to `clk` by the chip's reset logic.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin change first appears in `raw_o` after the third rising clock edge that follows it. It is not visible after the second.
- R2: An edge-sensed pin (`sense_i` bit 0) with `both_i` bit 0 and `pol_i` bit 1 sets its raw bit only on a 0-to-1 change. A 1-to-0 change leaves the bit unchanged.
- R3: An edge-sensed pin with `both_i` bit 0 and `pol_i` bit 0 sets its raw bit only on a 1-to-0 change. A 0-to-1 change leaves the bit unchanged.
- R4: An edge-sensed pin with `both_i` bit 1 sets its raw bit on either direction of change.
- R5: A level-sensed pin (`sense_i` bit 1) sets its raw bit on every cycle in which its synchronized value equals its `pol_i` bit. This holds whatever its `dir_i` bit is.
- R6: Edge detection ignores pins whose `dir_i` bit is 1, which marks an output. The previous-sample register still follows them, so switching such a pin back to input does not report an old change.
- R7: A cycle with `clr_we_i` high clears every raw bit whose `clr_val_i` bit is 1. Raw bits whose `clr_val_i` bit is 0 are kept.
- R8: When a set condition and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `masked_o` equals `raw_o` AND `mask_i`. `irq_o` is high exactly when `masked_o` is non-zero. Both follow `mask_i` without a register stage.
- R10: Reset clears the raw status, the synchronizer and the previous-sample register. After reset, `raw_o` is 0 and `irq_o` is 0.
- R11: Without a clear, a raw bit stays set after its cause has gone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 8 | Pin values, asynchronous to `clk` |
| dir_i | input | 8 | Per-pin direction, 1 = output, 0 = input |
| sense_i | input | 8 | Per-pin sensing, 0 = edge, 1 = level |
| both_i | input | 8 | Per-pin edge selection, 1 = both edges |
| pol_i | input | 8 | Per-pin polarity, 1 = rising/high, 0 = falling/low |
| mask_i | input | 8 | Per-pin interrupt enable |
| clr_we_i | input | 1 | Clear strobe, one cycle per write |
| clr_val_i | input | 8 | Clear value, 1 bits clear raw status |
| raw_o | output | 8 | Sticky raw interrupt status |
| masked_o | output | 8 | Raw status AND mask |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- raw bits never fall without a clear, and a clear empties bits that had no pending event;
- a matching level always shows up in the raw status one edge later, even when a clear hits it;
- output pins never raise an edge-mode bit;
- the request line and masked status stay consistent with raw status and mask.

Only the bench's scenarios can show the three-edge latency, the choice of edge under each polarity and both-edge setting, and that switching a pin from output to input reports nothing old. The behavioural reference model, compared every cycle, covers the exact cycle at which each bit sets or clears.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  // Per-pin configuration gathered from the configuration inputs
  typedef struct packed {
    logic is_out;     // 1: pin drives, edge detection ignores it
    logic level;      // 1: level sensing, 0: edge sensing
    logic any_edge;   // 1: both edges count
    logic active_hi;  // rising edge / high level when 1
  } pin_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stages_q;
  logic [STAGES-1:0][WIDTH-1:0] stages_d;

  always_comb begin
    stages_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      stages_d[i] = stages_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages_q <= '0;
    end else begin
      stages_q <= stages_d;
    end
  end

  assign sync_o = stages_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_pin_det.sv
`timescale 1ns/1ps
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic     cur_i,
  input  logic     prev_i,
  input  pin_cfg_t cfg_i,
  output logic     hit_o
);

  logic changed;
  logic at_pol;

  always_comb begin
    changed = (cur_i ^ prev_i) & ~cfg_i.is_out;
    at_pol  = ~(cur_i ^ cfg_i.active_hi);
    if (cfg_i.level) begin
      hit_o = at_pol;
    end else begin
      hit_o = changed & (cfg_i.any_edge | at_pol);
    end
  end

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_val_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] raw_o,
  output logic [WIDTH-1:0] masked_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] raw_q;
  logic [WIDTH-1:0] raw_d;
  logic [WIDTH-1:0] clr_bits;
  logic             raw_en;

  // set is applied after clear, so a same-cycle set wins
  always_comb begin
    clr_bits = clr_we_i ? clr_val_i : '0;
    raw_en   = clr_we_i | (|set_i);
    raw_d    = (raw_q & ~clr_bits) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
  assign irq_o    = |masked_o;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_val_i,
  output logic [NPINS-1:0] raw_o,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);

  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] pin_prev;
  logic [NPINS-1:0] prev_d;
  logic [NPINS-1:0] hit;

  gpio_irq_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  // previous-sample register follows every pin, input or output
  always_comb begin
    prev_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= '0;
    end else begin
      pin_prev <= prev_d;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{is_out:    dir_i[p],
                   level:     sense_i[p],
                   any_edge:  both_i[p],
                   active_hi: pol_i[p]};
    gpio_irq_pin_det u_det (
      .cur_i  (pin_s[p]),
      .prev_i (pin_prev[p]),
      .cfg_i  (cfg),
      .hit_o  (hit[p])
    );
  end

  gpio_irq_status #(
    .WIDTH (NPINS)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (hit),
    .clr_we_i  (clr_we_i),
    .clr_val_i (clr_val_i),
    .mask_i    (mask_i),
    .raw_o     (raw_o),
    .masked_o  (masked_o),
    .irq_o     (irq_o)
  );

endmodule

// File: rtl/gpio_irq_checker.sv
`timescale 1ns/1ps
module gpio_irq_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dir_i,
  input logic [WIDTH-1:0] sense_i,
  input logic [WIDTH-1:0] pol_i,
  input logic [WIDTH-1:0] mask_i,
  input logic             clr_we_i,
  input logic [WIDTH-1:0] clr_val_i,
  input logic [WIDTH-1:0] pin_s,
  input logic [WIDTH-1:0] pin_prev,
  input logic [WIDTH-1:0] raw_o,
  input logic [WIDTH-1:0] masked_o,
  input logic             irq_o
);

  logic [WIDTH-1:0] lvl_hit;
  logic [WIDTH-1:0] quiet_clr;
  logic [WIDTH-1:0] out_edge;

  assign lvl_hit   = sense_i & ~(pin_s ^ pol_i);
  assign quiet_clr = clr_val_i & ~sense_i & ~(pin_s ^ pin_prev);
  assign out_edge  = dir_i & ~sense_i;

  // R11: without a clear no raw bit falls
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

  // R7: cleared bits with no pending event are empty next cycle
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((raw_o & $past(quiet_clr)) == '0));

  // R5 and R8: a matching level is set next cycle, even under a clear
  assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_o & $past(lvl_hit)) == $past(lvl_hit)));

  // R6: output pins in edge mode never raise a raw bit
  assert_out_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_o & ~$past(raw_o) & $past(out_edge)) == '0));

  // R9: request line and masked status agree with raw and mask
  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw_o & mask_i) != '0));

  assert_noirq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> ((raw_o & mask_i) == '0));

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_o & ~raw_o) == '0) && ((masked_o & ~mask_i) == '0));

endmodule

bind gpio_irq_detect gpio_irq_checker #(.WIDTH(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_i     (dir_i),
  .sense_i   (sense_i),
  .pol_i     (pol_i),
  .mask_i    (mask_i),
  .clr_we_i  (clr_we_i),
  .clr_val_i (clr_val_i),
  .pin_s     (pin_s),
  .pin_prev  (pin_prev),
  .raw_o     (raw_o),
  .masked_o  (masked_o),
  .irq_o     (irq_o)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin, dir, sense, both, pol, mask, clr_val;
  logic       clr_we;
  logic [7:0] raw_o, masked_o;
  logic       irq_o;

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 1'b0;
  string cur_req  = "R10";

  always #2 clk = ~clk;

  gpio_irq_detect uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .dir_i     (dir),
    .sense_i   (sense),
    .both_i    (both),
    .pol_i     (pol),
    .mask_i    (mask),
    .clr_we_i  (clr_we),
    .clr_val_i (clr_val),
    .raw_o     (raw_o),
    .masked_o  (masked_o),
    .irq_o     (irq_o)
  );

  // behavioural reference model
  logic [7:0] syncq[$];
  logic [7:0] m_prev, m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncq.delete();
      syncq.push_back(8'h00);
      syncq.push_back(8'h00);
      m_prev = 8'h00;
      m_raw  = 8'h00;
    end else begin
      logic [7:0] s;
      logic [7:0] setv;
      s    = syncq[0];
      setv = 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (sense[i]) begin
          if (s[i] == pol[i]) setv[i] = 1'b1;
        end else if (!dir[i] && (s[i] != m_prev[i])) begin
          if (both[i] || (s[i] == pol[i])) setv[i] = 1'b1;
        end
      end
      if (clr_we) m_raw = m_raw & ~clr_val;
      m_raw  = m_raw | setv;
      m_prev = s;
      void'(syncq.pop_front());
      syncq.push_back(pin);
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (raw_o !== m_raw || masked_o !== (m_raw & mask) ||
          irq_o !== |(m_raw & mask)) begin
        failures++;
        $display("FAIL %s per-cycle: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                 cur_req, raw_o, masked_o, irq_o, m_raw, m_raw & mask, |(m_raw & mask));
      end
    end
  end

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(logic [7:0] v);
    clr_we  = 1'b1;
    clr_val = v;
    step(1);
    clr_we  = 1'b0;
    clr_val = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 8'h00; dir = 8'h00; sense = 8'h00; both = 8'h00;
    pol = 8'hff; mask = 8'hff; clr_we = 1'b0; clr_val = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10: reset state
    check8("R10", "raw after reset", raw_o, 8'h00);
    check8("R10", "irq after reset", {7'd0, irq_o}, 8'h00);

    // R1, R2: rising edge with polarity high
    cur_req = "R2";
    pin = 8'h01;
    step(2);
    check8("R1", "raw after two edges", raw_o, 8'h00);
    step(1);
    check8("R1", "raw after three edges", raw_o, 8'h01);
    step(5);
    check8("R11", "raw kept without clear", raw_o, 8'h01);
    clear(8'hff);
    pin = 8'h00;
    step(4);
    check8("R2", "falling edge ignored", raw_o, 8'h00);

    // R3: falling edge with polarity low
    cur_req = "R3";
    pol = 8'h00;
    pin = 8'h02;
    step(4);
    check8("R3", "rising edge ignored", raw_o, 8'h00);
    pin = 8'h00;
    step(4);
    check8("R3", "falling edge sets", raw_o, 8'h02);
    clear(8'hff);

    // R4: both edges
    cur_req = "R4";
    both = 8'hff;
    pin = 8'h04;
    step(4);
    check8("R4", "rising sets", raw_o, 8'h04);
    clear(8'hff);
    pin = 8'h00;
    step(4);
    check8("R4", "falling sets", raw_o, 8'h04);
    clear(8'hff);
    both = 8'h00;

    // R6: output pin ignored for edges
    cur_req = "R6";
    pol = 8'hff;
    dir = 8'h08;
    pin = 8'h08;
    step(4);
    check8("R6", "output rising ignored", raw_o, 8'h00);
    pin = 8'h00;
    step(4);
    check8("R6", "output falling ignored", raw_o, 8'h00);
    dir = 8'h00;
    step(3);
    check8("R6", "no stale change after turning to input", raw_o, 8'h00);

    // R5, R8: level sensing
    cur_req = "R5";
    sense = 8'h10;
    pol = 8'h10;
    step(3);
    check8("R5", "level high inactive while pin low", raw_o, 8'h00);
    pin = 8'h10;
    step(3);
    check8("R5", "level high sets", raw_o, 8'h10);
    cur_req = "R8";
    clear(8'h10);
    check8("R8", "set wins over clear", raw_o, 8'h10);
    pin = 8'h00;
    step(3);
    clear(8'h10);
    check8("R7", "clear after level gone", raw_o, 8'h00);
    cur_req = "R5";
    pol = 8'h00;
    dir = 8'h10;
    step(1);
    check8("R5", "level low on output pin sets", raw_o, 8'h10);
    sense = 8'h00;
    dir = 8'h00;
    pol = 8'hff;
    clear(8'hff);
    check8("R7", "clear all", raw_o, 8'h00);

    // R7: partial clear
    cur_req = "R7";
    both = 8'hff;
    pin = 8'h60;
    step(4);
    check8("R7", "two bits set", raw_o, 8'h60);
    clear(8'h20);
    check8("R7", "only selected bit cleared", raw_o, 8'h40);

    // R9: mask and request line
    cur_req = "R9";
    mask = 8'h00;
    step(1);
    check8("R9", "masked with mask 0", masked_o, 8'h00);
    check8("R9", "irq with mask 0", {7'd0, irq_o}, 8'h00);
    mask = 8'h40;
    step(1);
    check8("R9", "masked with bit 6", masked_o, 8'h40);
    check8("R9", "irq with bit 6", {7'd0, irq_o}, 8'h01);
    mask = 8'h20;
    step(1);
    check8("R9", "irq with bit 5 only", {7'd0, irq_o}, 8'h00);
    clear(8'hff);
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule